// File: doc/BRIEF.md
# Prioritised Interrupt Level Arbiter

This block takes fifteen asynchronous interrupt request lines and turns them into a single trap request for the processor's trap sequencer. Each line stands for one priority level from 1 to 15, and 15 is the most urgent. Level 0 means that nothing is pending. The lines pass through a two-flop synchronizer. The block then picks the most urgent pending level and tests it against the processor's current interrupt mask level and its trap-enable bit. When the level survives that test, the block raises `take_trap` and reports the winning level together with a trap type code.

The mask comparison is strict: a request is accepted only when its level lies above the mask, so a mask of 0 lets every level through. Level 15 bypasses the mask and is refused only while trap enable is low. The block never changes the mask; the mask is a plain input. An accepted trap is held until the sequencer acknowledges it. On the acknowledge edge, the stale copies of the acknowledged level are removed from the synchronizer. On the next edge the block arbitrates again among whatever requests are still pending.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is held, `take_trap` is 0 and `trap_level` is 0.
- R2: Bit k of `irq_req` is a request at level k+1. When several levels are pending and accepted, `trap_level` reports the highest one.
- R3: For levels 1 to 14, a request whose level is less than or equal to `mask_level` never raises `take_trap`.
- R4: A level-15 request raises `take_trap` whenever `trap_en` is 1, including when `mask_level` is 15.
- R5: While `trap_en` is 0, no new trap is raised, whatever the requests and mask.
- R6: `trap_type` equals 0x10 plus `trap_level`, as 8-bit hexadecimal.
- R7: An accepted request that is applied ahead of a rising edge shows on `take_trap` after the third rising edge, and not after the second.
- R8: Once `take_trap` is 1, it and `trap_level` stay unchanged until `trap_ack` is sampled high, even if the requests, the mask or `trap_en` change meanwhile.
- R9: On the edge where `trap_ack` is sampled high with `take_trap` at 1, `take_trap` falls and the acknowledged level is removed from the synchronizer. On the next edge, any other pending level that is accepted is raised. A source that dropped its line by the acknowledge edge is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Request lines; bit k is level k+1 |
| mask_level | input | 4 | Current processor interrupt mask level |
| trap_en | input | 1 | Trap-enable bit; 0 refuses new requests |
| trap_ack | input | 1 | Acknowledge of the held trap from the trap sequencer |
| take_trap | output | 1 | A trap request is held |
| trap_level | output | 4 | Level of the held trap; 0 when none is held |
| trap_type | output | 8 | Trap type code, 0x10 plus the level |

## Verification
A request applied on a falling edge passes two synchronizer flops and one hold register. It is therefore due on `take_trap` after the third rising edge. The bench samples on the falling edge after the second rising edge, where it expects 0, and on the falling edge after the third, where it expects the computed result. After an acknowledge, `take_trap` is checked one falling edge after the acknowledge edge. A remaining level is checked one edge later again. After the lines are cleared, the bench waits three more edges before it confirms that nothing was taken twice. The sweep covers every mask level against every single level with trap enable both on and off, plus a set of computed multi-line patterns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_LEVELS = 16;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int REQ_W      = NUM_LEVELS - 1;
  localparam int TT_W       = 8;
  localparam logic [TT_W-1:0] TT_BASE = 8'h10;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [REQ_W-1:0] req_t;

  localparam level_t NMI_LEVEL = level_t'(NUM_LEVELS - 1);

  // Highest pending level; bit k of the vector is level k+1.
  function automatic level_t top_level(req_t v);
    level_t r;
    r = '0;
    for (int k = 0; k < REQ_W; k++)
      if (v[k]) r = level_t'(k + 1);
    return r;
  endfunction

  // Acceptance rule: strict compare against mask, top level unmaskable.
  function automatic logic passes_mask(level_t lvl, level_t mask, logic en);
    return en && (lvl != '0) && ((lvl > mask) || (lvl == NMI_LEVEL));
  endfunction

  function automatic logic [TT_W-1:0] trap_type_of(level_t lvl);
    return TT_BASE + TT_W'(lvl);
  endfunction

  // One-hot request bit of a level; empty for level 0.
  function automatic req_t level_bit(level_t lvl);
    req_t r;
    r = '0;
    if (lvl != '0) r = req_t'(1) << (lvl - level_t'(1));
    return r;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 15,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] drop,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din & ~drop;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1] & ~drop;
      end
    end
  end

  assign dout = stg[STAGES-1];

  // A dropped bit must not survive into the synchronized output.
  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop != '0) |=> ((dout & $past(drop)) == '0));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
(
  input  req_t   req,
  input  level_t mask,
  input  logic   en,
  output level_t win,
  output logic   hit
);
  always_comb begin
    win = top_level(req);
    hit = passes_mask(win, mask, en);
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold
  import irq_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  level_t win,
  input  logic   ack,
  output logic   take,
  output level_t lvl,
  output logic   consumed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take <= 1'b0;
      lvl  <= '0;
    end else if (take) begin
      if (ack) begin
        take <= 1'b0;
        lvl  <= '0;
      end
    end else if (hit) begin
      take <= 1'b1;
      lvl  <= win;
    end
  end

  assign consumed = take && ack;

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack) |=> (take && $stable(lvl)));

  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> !take);

  assert_rise_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> ($past(hit) && (lvl == $past(win))));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REQ_W-1:0]     irq_req,
  input  logic [LVL_W-1:0]     mask_level,
  input  logic                 trap_en,
  input  logic                 trap_ack,
  output logic                 take_trap,
  output logic [LVL_W-1:0]     trap_level,
  output logic [TT_W-1:0]      trap_type
);
  req_t   req_synced;
  req_t   drop_bits;
  level_t sel_win;
  logic   sel_hit;
  logic   ack_taken;

  irq_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_req),
    .drop (drop_bits),
    .dout (req_synced)
  );

  irq_select u_select (
    .req (req_synced),
    .mask(mask_level),
    .en  (trap_en),
    .win (sel_win),
    .hit (sel_hit)
  );

  irq_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (sel_hit),
    .win     (sel_win),
    .ack     (trap_ack),
    .take    (take_trap),
    .lvl     (trap_level),
    .consumed(ack_taken)
  );

  assign drop_bits = ack_taken ? level_bit(trap_level) : '0;
  assign trap_type = trap_type_of(trap_level);

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_trap) |-> $past(trap_en));

  assert_strict_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_trap) |-> ((trap_level > $past(mask_level)) || (trap_level == NMI_LEVEL)));

  assert_top_unmaskable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_win == NMI_LEVEL && trap_en && !take_trap) |=> take_trap);

  assert_nonzero_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> (trap_level != '0));
endmodule

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_req = '0;
  logic [3:0]  mask_level = '0;
  logic        trap_en = 1'b0;
  logic        trap_ack = 1'b0;
  logic        take_trap;
  logic [3:0]  trap_level;
  logic [7:0]  trap_type;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_level(mask_level),
    .trap_en(trap_en), .trap_ack(trap_ack), .take_trap(take_trap),
    .trap_level(trap_level), .trap_type(trap_type)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_level(input logic [14:0] r);
    for (int lv = 15; lv >= 1; lv--)
      if (r[lv-1]) return lv;
    return 0;
  endfunction

  task automatic run_case(input logic [14:0] r, input int m, input bit en);
    int  lv;
    bit  exp_take;
    string tag;
    lv = ref_level(r);
    exp_take = en && lv != 0 && (lv > m || lv == 15);
    if (!en) tag = "R5";
    else if (lv == 15 && m == 15) tag = "R4";
    else if (lv != 0 && lv <= m) tag = "R3";
    else tag = "R2";
    @(negedge clk);
    irq_req = r; mask_level = 4'(m); trap_en = en; trap_ack = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7", int'(take_trap), 0);
    @(posedge clk); @(negedge clk);
    chk(tag, int'(take_trap), int'(exp_take));
    if (exp_take) begin
      chk("R2", int'(trap_level), lv);
      chk("R6", int'(trap_type), 16 + lv);
      irq_req = '0; trap_en = 1'b0; mask_level = 4'd15;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R8", int'(take_trap), 1);
      chk("R8", int'(trap_level), lv);
      trap_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      trap_ack = 1'b0;
      chk("R9", int'(take_trap), 0);
      trap_en = 1'b1; mask_level = 4'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", int'(take_trap), 0);
    end else begin
      irq_req = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tag, int'(take_trap), 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    irq_req = 15'h7FFF; trap_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(take_trap), 0);
    chk("R1", int'(trap_level), 0);
    irq_req = '0; trap_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep: every mask against every single level, enable on and off.
    for (int m = 0; m < 16; m++)
      for (int lv = 1; lv <= 15; lv++)
        for (int e = 0; e < 2; e++)
          run_case(15'(1) << (lv - 1), m, e[0]);

    // Computed multi-line patterns.
    for (int p = 0; p < 64; p++)
      run_case(15'(p * 32'h2D1 + p * p * 7), p % 16, (p % 5) != 0);

    // R9: two levels pending, higher acknowledged, lower follows.
    @(negedge clk);
    irq_req = (15'(1) << 8) | (15'(1) << 4); mask_level = 4'd0; trap_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", int'(trap_level), 9);
    irq_req = 15'(1) << 4; trap_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    trap_ack = 1'b0;
    chk("R9", int'(take_trap), 0);
    @(posedge clk); @(negedge clk);
    chk("R9", int'(take_trap), 1);
    chk("R9", int'(trap_level), 5);
    irq_req = '0; trap_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    trap_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", int'(take_trap), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule